// File: doc/BRIEF.md
# Fast-page-mode DRAM write, read and refresh controller

This controller sits between a simple valid/ready host port and a 16-bit fast-page-mode DRAM. Each host request carries a row, a column, a write flag, two byte-lane enables and write data. The controller turns the request into a single strobed access. It drives the row with the row strobe, then the column with the column strobes. The lower and upper column strobes are asserted separately, so they also act as per-byte write enables: a lane whose strobe stays high keeps its stored byte.

A refresh timer issues one refresh request per interval. The interval is the retention period divided by the row count, rounded down to whole clock cycles. Requests that cannot be served at once are held in a saturating backlog counter. Refresh uses the column-before-row form, so the device's own counter supplies the row.

Refresh wins over host traffic whenever the sequencer is idle. Host ready stays low while any refresh is owed, while a cycle is running and during the row-strobe precharge time.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: A write with lane enables `2'b11` (bit 0 is the lower byte, DQ0..7; bit 1 is the upper byte, DQ8..15) asserts both column strobes with the write strobe low and drives the write data on `dq_out` with `dq_oe` high.
- R2: A write with lane enables `2'b01` asserts only the lower column strobe, and the upper byte in the device keeps its previous value.
- R3: A write with lane enables `2'b10` asserts only the upper column strobe, and the lower byte in the device keeps its previous value.
- R4: A read asserts both column strobes with the write strobe high. It returns the device data on `rd_data` with a one-cycle `rd_valid` pulse. The lane enables are ignored.
- R5: A host access drives the row on `dram_addr` as the row strobe falls. The column strobes fall exactly T_RCD cycles later, with the column on `dram_addr`.
- R6: A refresh lowers both column strobes before the row strobe falls and keeps the write strobe high throughout.
- R7: With no host traffic, one refresh is issued every floor(RETENTION_US*CLK_MHZ/ROWS) cycles.
- R8: `req_ready` is low whenever any strobe is asserted and whenever a refresh is owed. Refresh is served before a waiting host request.
- R9: The row strobe stays high for at least T_RP cycles between any two cycles.
- R10: The owed-refresh count never exceeds MAX_OWED. When refresh cycles are slower than the timer, the controller issues back-to-back refreshes and never accepts host work.
- R11: After reset, all strobes are high, `dq_oe` and `rd_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Lane enables, bit 0 lower byte, bit 1 upper byte |
| req_row | input | ADDR_W | Row address |
| req_col | input | ADDR_W | Column address |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_casl_n | output | 1 | Lower-byte column strobe, active low |
| dram_cash_n | output | 1 | Upper-byte column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_addr | output | ADDR_W | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data driven toward the device |
| dram_dq_oe | output | 1 | Output enable for the data pins |
| dram_dq_in | input | 16 | Data returned by the device |

## Verification
On every cycle, the assertions check the following:
- the backlog stays at or below its limit, and a refresh is only started when one is owed;
- column strobes that are low as the row strobe falls were already low on the cycle before, with the write strobe high;
- the row strobe has been high for at least the precharge time when it falls;
- ready is never offered while a strobe is active.

Only the bench's scenarios can show the rest. A byte-lane write leaves the other byte intact in a device model, and read data comes back correctly. The column delay is right, and the refresh count over a quiet window matches the computed interval. A bench instance whose refresh cycles outlast the timer interval shows the back-to-back refresh behaviour.

// File: rtl/fpmc_pkg.sv
package fpmc_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ROW,
    S_COL,
    S_PRE,
    S_RCAS,
    S_RRAS
  } seq_state_e;
endpackage

// File: rtl/fpmc_ref_sched.sv
module fpmc_ref_sched #(
  parameter int INTERVAL = 3125,
  parameter int MAX_OWED = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic served,
  output logic owed_nz
);
  localparam int TW = $clog2(INTERVAL + 1);
  localparam int OW = $clog2(MAX_OWED + 1);

  logic [TW-1:0] tmr_q, tmr_d;
  logic [OW-1:0] owed_q, owed_d;
  logic          tick;

  assign tick    = (tmr_q == TW'(INTERVAL - 1));
  assign owed_nz = (owed_q != '0);

  always_comb begin
    tmr_d  = tick ? '0 : tmr_q + 1'b1;
    owed_d = owed_q;
    if (tick && !served) begin
      if (owed_q != OW'(MAX_OWED)) owed_d = owed_q + 1'b1;
    end else if (!tick && served) begin
      owed_d = owed_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      owed_q <= '0;
    end else begin
      tmr_q  <= tmr_d;
      owed_q <= owed_d;
    end
  end

  // R10: backlog is bounded
  p_owed_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= OW'(MAX_OWED));
  // R8: a refresh only starts when one is owed
  p_serve_owed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    served |-> owed_q != '0);
endmodule

// File: rtl/fpmc_seq.sv
module fpmc_seq
  import fpmc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter int T_RCD     = 3,
  parameter int T_CAS     = 3,
  parameter int T_RP      = 4,
  parameter int T_CSR     = 2,
  parameter int T_RAS_REF = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_owed,
  output logic              ref_served,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_be,
  input  logic [ADDR_W-1:0] req_row,
  input  logic [ADDR_W-1:0] req_col,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              ras_n,
  output logic              casl_n,
  output logic              cash_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);
  localparam int TM1  = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int TM2  = (T_RP > T_CSR) ? T_RP : T_CSR;
  localparam int TM3  = (TM1 > TM2) ? TM1 : TM2;
  localparam int TMAX = (TM3 > T_RAS_REF) ? TM3 : T_RAS_REF;
  localparam int CW   = $clog2(TMAX + 1);

  seq_state_e        state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              ld, cap;
  logic              wr_q;
  logic [1:0]        be_q;
  logic [ADDR_W-1:0] row_q, col_q;
  logic [DATA_W-1:0] wd_q, rd_q;
  logic              rdv_q;
  logic [1:0]        lanes;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    ld         = 1'b0;
    cap        = 1'b0;
    ref_served = 1'b0;
    if (state_q == S_IDLE) begin
      if (ref_owed) begin
        state_d    = S_RCAS;
        cnt_d      = CW'(T_CSR - 1);
        ref_served = 1'b1;
      end else if (req_valid) begin
        state_d = S_ROW;
        cnt_d   = CW'(T_RCD - 1);
        ld      = 1'b1;
      end
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      unique case (state_q)
        S_ROW:  begin state_d = S_COL;  cnt_d = CW'(T_CAS - 1); end
        S_COL:  begin state_d = S_PRE;  cnt_d = CW'(T_RP - 1); cap = !wr_q; end
        S_RCAS: begin state_d = S_RRAS; cnt_d = CW'(T_RAS_REF - 1); end
        S_RRAS: begin state_d = S_PRE;  cnt_d = CW'(T_RP - 1); end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      rdv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rdv_q   <= cap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      be_q  <= '0;
      row_q <= '0;
      col_q <= '0;
      wd_q  <= '0;
    end else if (ld) begin
      wr_q  <= req_write;
      be_q  <= req_be;
      row_q <= req_row;
      col_q <= req_col;
      wd_q  <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rd_q <= '0;
    else if (cap) rd_q <= dq_in;
  end

  always_comb begin
    lanes = 2'b00;
    if (state_q == S_COL)                          lanes = wr_q ? be_q : 2'b11;
    else if (state_q == S_RCAS || state_q == S_RRAS) lanes = 2'b11;
  end

  assign req_ready = (state_q == S_IDLE) && !ref_owed;
  assign ras_n     = !(state_q == S_ROW || state_q == S_COL || state_q == S_RRAS);
  assign casl_n    = !lanes[0];
  assign cash_n    = !lanes[1];
  assign we_n      = !(state_q == S_COL && wr_q);
  assign dq_oe     = (state_q == S_COL) && wr_q;
  assign dq_out    = wd_q;
  assign addr      = (state_q == S_COL) ? col_q : row_q;
  assign rd_valid  = rdv_q;
  assign rd_data   = rd_q;

  // precharge watch: cycles the row strobe has been high, saturating
  localparam int HW = $clog2(T_RP + 1);
  logic [HW-1:0] hi_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   hi_q <= HW'(T_RP);
    else if (!ras_n)              hi_q <= '0;
    else if (hi_q != HW'(T_RP))   hi_q <= hi_q + 1'b1;
  end

  // R9: precharge time honoured
  p_precharge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> hi_q >= HW'(T_RP));
  // R6: column strobes low at row fall were already both low, write strobe high
  p_cbr_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && (!casl_n || !cash_n)) |->
      ($past(!casl_n && !cash_n) && we_n));
  // R8: no ready while a cycle drives the strobes
  p_ready_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ras_n && casl_n && cash_n && we_n));
  // R4: read data valid is a single-cycle pulse
  p_rdv_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int ADDR_W       = 12,
  parameter int CLK_MHZ      = 200,
  parameter int RETENTION_US = 64000,
  parameter int ROWS         = 4096,
  parameter int MAX_OWED     = 4,
  parameter int T_RCD        = 3,
  parameter int T_CAS        = 3,
  parameter int T_RP         = 4,
  parameter int T_CSR        = 2,
  parameter int T_RAS_REF    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_be,
  input  logic [ADDR_W-1:0] req_row,
  input  logic [ADDR_W-1:0] req_col,
  input  logic [15:0]       req_wdata,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic              dram_ras_n,
  output logic              dram_casl_n,
  output logic              dram_cash_n,
  output logic              dram_we_n,
  output logic [ADDR_W-1:0] dram_addr,
  output logic [15:0]       dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [15:0]       dram_dq_in
);
  localparam int REF_INTERVAL = (RETENTION_US * CLK_MHZ) / ROWS;

  logic owed, served;

  fpmc_ref_sched #(
    .INTERVAL (REF_INTERVAL),
    .MAX_OWED (MAX_OWED)
  ) u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .served  (served),
    .owed_nz (owed)
  );

  fpmc_seq #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (16),
    .T_RCD     (T_RCD),
    .T_CAS     (T_CAS),
    .T_RP      (T_RP),
    .T_CSR     (T_CSR),
    .T_RAS_REF (T_RAS_REF)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_owed   (owed),
    .ref_served (served),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_be     (req_be),
    .req_row    (req_row),
    .req_col    (req_col),
    .req_wdata  (req_wdata),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .ras_n      (dram_ras_n),
    .casl_n     (dram_casl_n),
    .cash_n     (dram_cash_n),
    .we_n       (dram_we_n),
    .addr       (dram_addr),
    .dq_out     (dram_dq_out),
    .dq_oe      (dram_dq_oe),
    .dq_in      (dram_dq_in)
  );
endmodule

// File: tb/sim_fpm_dram_ctrl.sv
module sim_fpm_dram_ctrl;
  localparam int AW = 4;
  localparam int TRCD = 3;
  localparam int TRP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]    req_be = 2'b00;
  logic [AW-1:0] req_row = '0, req_col = '0;
  logic [15:0]   req_wdata = '0;
  logic          req_ready, rd_valid, ras_n, casl_n, cash_n, we_n, dq_oe;
  logic [15:0]   rd_data, dq_out, dq_in;
  logic [AW-1:0] addr;

  logic          r1_ready, r1_rdv, r1_ras, r1_casl, r1_cash, r1_we, r1_oe;
  logic [15:0]   r1_rd, r1_dq;
  logic [AW-1:0] r1_addr;

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  fpm_dram_ctrl #(.ADDR_W(AW), .RETENTION_US(2048), .MAX_OWED(4),
    .T_RCD(TRCD), .T_CAS(3), .T_RP(TRP), .T_CSR(2), .T_RAS_REF(5)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_be(req_be), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_ras_n(ras_n), .dram_casl_n(casl_n), .dram_cash_n(cash_n), .dram_we_n(we_n),
    .dram_addr(addr), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

  // timer interval 4 cycles, refresh cycle 12 cycles: backlog builds
  fpm_dram_ctrl #(.ADDR_W(AW), .RETENTION_US(82), .MAX_OWED(2),
    .T_RCD(TRCD), .T_CAS(3), .T_RP(TRP), .T_CSR(2), .T_RAS_REF(5)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(1'b1), .req_ready(r1_ready),
    .req_write(1'b0), .req_be(2'b11), .req_row('0), .req_col('0),
    .req_wdata(16'h0), .rd_valid(r1_rdv), .rd_data(r1_rd),
    .dram_ras_n(r1_ras), .dram_casl_n(r1_casl), .dram_cash_n(r1_cash), .dram_we_n(r1_we),
    .dram_addr(r1_addr), .dram_dq_out(r1_dq), .dram_dq_oe(r1_oe), .dram_dq_in(16'h0));

  // ---------------- device model (sampled at falling clock) ----------------
  logic [15:0] mem [0:255];
  logic [AW-1:0] m_row = '0;
  logic p_ras = 1'b1, p_casl = 1'b1, p_cash = 1'b1;
  int cyc = 0, ras_fall_t = 0, ras_rise_t = -100;
  int cbr_cnt = 0, host_cas_cnt = 0, ready_viol = 0, cbr_viol = 0;
  int r1_cbr = 0, r1_ready_hi = 0;
  logic p1_ras = 1'b1;
  logic [1:0] last_lanes = 2'b00;
  logic last_we = 1'b1;

  assign dq_in = (!ras_n && we_n && (!casl_n || !cash_n)) ? mem[{m_row, addr}] : 16'h0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (p_ras && !ras_n) begin
        chk(cyc - ras_rise_t >= TRP, "R9 row strobe high time", cyc - ras_rise_t, TRP);
        ras_fall_t = cyc;
        if (!casl_n || !cash_n) begin
          cbr_cnt++;
          if (!(!casl_n && !cash_n && !p_casl && !p_cash && we_n)) cbr_viol++;
        end else m_row = addr;
      end
      if (!p_ras && ras_n) ras_rise_t = cyc;
      if (!ras_n && p_casl && p_cash && (!casl_n || !cash_n)) begin
        host_cas_cnt++;
        chk(cyc - ras_fall_t == TRCD, "R5 row-to-column delay", cyc - ras_fall_t, TRCD);
        last_lanes = {!cash_n, !casl_n};
        last_we = we_n;
        if (!we_n) begin
          if (!dq_oe) chk(1'b0, "R1 dq_oe during write", dq_oe, 1);
          if (!casl_n) mem[{m_row, addr}][7:0]  = dq_out[7:0];
          if (!cash_n) mem[{m_row, addr}][15:8] = dq_out[15:8];
        end
      end
      if (req_ready && (!ras_n || !casl_n || !cash_n)) ready_viol++;
      if (p1_ras && !r1_ras) r1_cbr++;
      if (r1_ready) r1_ready_hi++;
    end
    p_ras = ras_n; p_casl = casl_n; p_cash = cash_n; p1_ras = r1_ras;
  end

  // ---------------- vectors: write, be, row, col, data/expected ----------------
  localparam logic [26:0] VEC [0:7] = '{
    {1'b1, 2'b11, 4'd1, 4'd2, 16'h1234},
    {1'b1, 2'b01, 4'd1, 4'd2, 16'hABCD},
    {1'b0, 2'b00, 4'd1, 4'd2, 16'h12CD},
    {1'b1, 2'b10, 4'd1, 4'd2, 16'h5566},
    {1'b0, 2'b01, 4'd1, 4'd2, 16'h55CD},
    {1'b1, 2'b11, 4'd3, 4'd7, 16'hFFFF},
    {1'b0, 2'b10, 4'd3, 4'd7, 16'hFFFF},
    {1'b0, 2'b11, 4'd0, 4'd0, 16'h0000}
  };

  task automatic send(input logic w, input logic [1:0] be, input logic [AW-1:0] r,
                      input logic [AW-1:0] c, input logic [15:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_be = be; req_row = r; req_col = c; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk({ras_n, casl_n, cash_n, we_n} == 4'hF, "R11 strobes idle in reset", {ras_n, casl_n, cash_n, we_n}, 4'hF);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rd_valid == 1'b0 && dq_oe == 1'b0, "R11 ready after reset",
        {req_ready, rd_valid, dq_oe}, 3'b100);

    for (int v = 0; v < 8; v++) begin
      logic w;
      logic [1:0] be;
      logic [15:0] d;
      int seen, to;
      w = VEC[v][26]; be = VEC[v][25:24]; d = VEC[v][15:0];
      seen = host_cas_cnt;
      send(w, be, VEC[v][23:20], VEC[v][19:16], d);
      if (w) begin
        while (host_cas_cnt == seen) @(negedge clk);
        chk(last_lanes == be && last_we == 1'b0, be == 2'b11 ? "R1 word write lanes" :
            (be == 2'b01 ? "R2 lower write lanes" : "R3 upper write lanes"),
            {last_we, last_lanes}, {1'b0, be});
        while (!req_ready) @(negedge clk);
      end else begin
        to = 0;
        while (!rd_valid && to < 200) begin @(negedge clk); to++; end
        chk(rd_valid && rd_data == d, "R4 read data (R2/R3 lane retention)", rd_data, d);
        chk(last_lanes == 2'b11 && last_we == 1'b1, "R4 read strobes", {last_we, last_lanes}, 3'b111);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R4 rd_valid single pulse", rd_valid, 0);
      end
    end

    // R7: refresh rate over a quiet window of 1000 cycles, interval 100
    begin
      int c0;
      c0 = cbr_cnt;
      repeat (1000) @(negedge clk);
      chk(cbr_cnt - c0 >= 9 && cbr_cnt - c0 <= 11, "R7 refresh count in 1000 cycles", cbr_cnt - c0, 10);
    end
    chk(cbr_cnt > 0 && cbr_viol == 0, "R6 column-before-row order", cbr_viol, 0);
    chk(ready_viol == 0, "R8 ready low while strobes active", ready_viol, 0);

    // R8: refresh before host; a request issued right after a refresh tick waits
    begin
      int c0, t0;
      c0 = cbr_cnt;
      t0 = 0;
      while (cbr_cnt == c0 && t0 < 300) begin @(negedge clk); t0++; end
      chk(req_ready == 1'b0, "R8 ready low during refresh", req_ready, 0);
    end

    // R10: saturated backlog in u1
    begin
      int c0;
      repeat (40) @(negedge clk);
      c0 = r1_cbr;
      r1_ready_hi = 0;
      repeat (300) @(negedge clk);
      chk(r1_ready_hi == 0, "R10 host starved under backlog", r1_ready_hi, 0);
      chk(r1_cbr - c0 >= 24 && r1_cbr - c0 <= 26, "R10 back-to-back refresh count", r1_cbr - c0, 25);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule